// File: doc/BRIEF.md
# Cascadable Parity Generator-Checker with Shared Port

This block computes the parity of a data word and shares a single parity line between two roles. In send mode it drives its own parity bit onto the line. In check mode it releases the line, treats the incoming value as the expected parity, and pulls an active-low error flag when the two disagree. The bidirectional line is modelled as three separate signals: a drive value, a drive enable and a sampled input. A pad-level tri-state buffer combines them outside this block.

The basic element is a nine-input stage. The top module chains as many stages as the parameter `DATA_W` needs. The first stage takes nine data bits. Each later stage takes the previous stage's parity bit plus eight new data bits. Unused lanes of the last stage are tied to zero. Only the final stage faces the line. The inner stages always generate parity.

A polarity select flips the generated bit and the check sense together. While the power-good input is low, the line is never driven and no error is reported.

Top module: `parity_port_cascade`

## Requirements
- R1: With `pwr_ok`=1, `chk_mode`=0 and `par_sel`=0, `pin_oe` is 1. `pin_out` is 1 when `data` holds an even number of ones and 0 when it holds an odd number.
- R2: With `pwr_ok`=1 and `chk_mode`=0, `err_n` stays 1 for every data value and every `pin_in` value.
- R3: With `chk_mode`=1, `pin_oe` is 0 for every data value and every `pin_in` value.
- R4: With `pwr_ok`=1, `chk_mode`=1 and `par_sel`=0, `err_n` is 0 exactly when the ones in `data` plus `pin_in` add up to an even number. Otherwise `err_n` is 1.
- R5: `par_sel`=1 inverts `pin_out` in send mode relative to R1. It also inverts the error condition of R4, so that `err_n` is 0 exactly when the total is odd.
- R6: While `pwr_ok`=0, `pin_oe` is 0 and `err_n` is 1, whatever the other inputs are.
- R7: For any `DATA_W`, the block uses 1+ceil((`DATA_W`-9)/8) stages (one stage when `DATA_W`<=9). Every data bit takes part in the result, so flipping any single bit of `data` flips `pin_out`. The results of R1 and R5 hold whether the stage count is odd or even.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pwr_ok | input | 1 | Power-good; low keeps the parity line released and the error flag inactive |
| chk_mode | input | 1 | 0 = send parity on the line, 1 = check the parity arriving on the line |
| par_sel | input | 1 | Polarity select; 1 inverts the generated bit and the check sense |
| data | input | DATA_W | Data word covered by the parity |
| pin_in | input | 1 | Sampled value of the parity line |
| pin_out | output | 1 | Value to drive on the parity line |
| pin_oe | output | 1 | Drive enable for the parity line |
| err_n | output | 1 | Active-low parity error flag |

## Verification
The bench uses a 16-bit word. This gives two stages, which exercises the correction for an even stage count, and one padded lane.

In send mode, all 512 patterns of the lower nine bits are crossed with varied upper bytes under both polarities. This separates an even count of ones from an odd count across the stage boundary.

In check mode, the same patterns are crossed with both line values and both polarities. This shows that the error appears only for the expected ten-bit total.

A walking one over every data bit proves that each bit reaches the result. A sweep with power-good low, across both modes, shows that the line stays released and no error is raised.

// File: rtl/parity_port_pkg.sv
package parity_port_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int STAGE_LANES = 9;
    localparam int CHAIN_LANES = STAGE_LANES - 1;

    typedef struct packed {
        logic drive_val;
        logic drive_en;
        logic err_n;
    } stage_out_t;

    function automatic int stage_count(input int width);
        if (width <= STAGE_LANES) begin
            return 1;
        end
        return 1 + (width - STAGE_LANES + CHAIN_LANES - 1) / CHAIN_LANES;
    endfunction
endpackage

// File: rtl/parity_port_stage.sv
module parity_port_stage
    import parity_port_pkg::*;
(
    input  logic                   pwr_ok,
    input  logic                   chk_mode,
    input  logic                   flip,
    input  logic [STAGE_LANES-1:0] lanes,
    input  logic                   pin_in,
    output stage_out_t             result
);
    timeunit 1ns;
    timeprecision 1ps;

    stage_out_t st_d;

    always_comb begin
        st_d.drive_val = ~(^lanes) ^ flip;
        st_d.drive_en  = pwr_ok && !chk_mode;
        st_d.err_n     = 1'b1;
        if (pwr_ok && chk_mode) begin
            st_d.err_n = (pin_in == st_d.drive_val);
        end
        result = st_d;

        // R1 R5
        tx_parity_chk: assert (st_d.drive_val ==
                               ((($countones(lanes) % 2) == 0) ^ flip));
        // R2
        if (pwr_ok && !chk_mode) begin
            tx_no_err_chk: assert (st_d.err_n);
        end
        // R3
        if (chk_mode) begin
            rx_release_chk: assert (!st_d.drive_en);
        end
        // R4 R5
        if (pwr_ok && chk_mode) begin
            rx_err_chk: assert (st_d.err_n ==
                                ((($countones({lanes, pin_in}) % 2) == 1) ^ flip));
        end
        // R6
        if (!pwr_ok) begin
            pwr_hiz_chk: assert (!st_d.drive_en && st_d.err_n);
        end
    end
endmodule

// File: rtl/parity_port_cascade.sv
module parity_port_cascade
    import parity_port_pkg::*;
#(
    parameter int DATA_W = 20
) (
    input  logic              pwr_ok,
    input  logic              chk_mode,
    input  logic              par_sel,
    input  logic [DATA_W-1:0] data,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              err_n
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int  STAGES   = stage_count(DATA_W);
    localparam int  PAD_W    = STAGE_LANES + CHAIN_LANES * (STAGES - 1);
    localparam int  LAST     = STAGES - 1;
    localparam bit  EVEN_FIX = (STAGES % 2) == 0;

    logic [PAD_W-1:0]   padded_d;
    stage_out_t         res_d [STAGES];
    logic [STAGES-1:0]  spare_oe;
    logic [STAGES-1:0]  spare_err;
    logic               unused_spare;

    assign padded_d = PAD_W'(data);

    genvar k;
    generate
        for (k = 0; k < STAGES; k++) begin : g_stage
            logic [STAGE_LANES-1:0] lanes_d;
            logic                   mode_d;
            logic                   flip_d;
            logic                   pwr_d;
            logic                   pin_d;

            if (k == 0) begin : g_head
                assign lanes_d = padded_d[STAGE_LANES-1:0];
            end else begin : g_link
                assign lanes_d = {padded_d[STAGE_LANES + CHAIN_LANES*(k-1) +: CHAIN_LANES],
                                  res_d[k-1].drive_val};
            end

            if (k == LAST) begin : g_face
                assign mode_d = chk_mode;
                assign flip_d = par_sel ^ EVEN_FIX;
                assign pwr_d  = pwr_ok;
                assign pin_d  = pin_in;
            end else begin : g_inner
                assign mode_d = 1'b0;
                assign flip_d = 1'b0;
                assign pwr_d  = 1'b1;
                assign pin_d  = 1'b0;
            end

            parity_port_stage u_stage (
                .pwr_ok   (pwr_d),
                .chk_mode (mode_d),
                .flip     (flip_d),
                .lanes    (lanes_d),
                .pin_in   (pin_d),
                .result   (res_d[k])
            );

            assign spare_oe[k]  = res_d[k].drive_en;
            assign spare_err[k] = res_d[k].err_n;
        end
    endgenerate

    assign unused_spare = ^{spare_oe, spare_err};

    assign pin_out = res_d[LAST].drive_val;
    assign pin_oe  = res_d[LAST].drive_en;
    assign err_n   = res_d[LAST].err_n;
endmodule

// File: tb/parity_port_cascade_test.sv
module parity_port_cascade_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         pwr_ok = 1'b0;
    logic         chk_mode = 1'b0;
    logic         par_sel = 1'b0;
    logic [W-1:0] data = '0;
    logic         pin_in = 1'b0;
    logic         pin_out;
    logic         pin_oe;
    logic         err_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    parity_port_cascade #(.DATA_W(W)) uut (
        .pwr_ok   (pwr_ok),
        .chk_mode (chk_mode),
        .par_sel  (par_sel),
        .data     (data),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .err_n    (err_n)
    );

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s data=%h sel=%0b mode=%0b pin_in=%0b got=%0b exp=%0b",
                     req, data, par_sel, chk_mode, pin_in, got, exp);
        end
    endtask

    task automatic apply(input logic p, input logic m, input logic s,
                         input logic [W-1:0] d, input logic pi);
        @(posedge clk);
        pwr_ok   <= p;
        chk_mode <= m;
        par_sel  <= s;
        data     <= d;
        pin_in   <= pi;
        @(negedge clk);
    endtask

    function automatic logic gen_bit(input logic [W-1:0] d, input logic s);
        return ((($countones(d) % 2) == 0) ? 1'b1 : 1'b0) ^ s;
    endfunction

    initial begin
        logic exp;
        // R6: reset state with power-good low
        apply(1'b0, 1'b0, 1'b0, '0, 1'b0);
        check(pin_oe, 1'b0, "R6 reset oe");
        check(err_n, 1'b1, "R6 reset err_n");

        // R1 R2 R5 R7: send-mode sweep
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 512; i++) begin
                logic [W-1:0] d;
                d = {7'((i * 37) ^ (i >> 2)), 9'(i)};
                apply(1'b1, 1'b0, 1'(s), d, 1'(i & 1));
                exp = gen_bit(d, 1'(s));
                check(pin_oe, 1'b1, "R1 oe");
                check(pin_out, exp, s ? "R5 tx polarity" : "R1 tx parity");
                check(err_n, 1'b1, "R2 no err in send");
            end
        end

        // R3 R4 R5: check-mode sweep
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 2; p++) begin
                for (int i = 0; i < 512; i++) begin
                    logic [W-1:0] d;
                    d = {7'((i * 91) + 5), 9'(i)};
                    apply(1'b1, 1'b1, 1'(s), d, 1'(p));
                    exp = (1'(p) == gen_bit(d, 1'(s)));
                    check(pin_oe, 1'b0, "R3 released");
                    check(err_n, exp, s ? "R5 rx polarity" : "R4 rx compare");
                end
            end
        end

        // R7: walking one flips the generated bit at every position
        for (int b = 0; b < W; b++) begin
            logic [W-1:0] d;
            d = W'(1) << b;
            apply(1'b1, 1'b0, 1'b0, d, 1'b0);
            check(pin_out, 1'b0, "R7 walk one");
            apply(1'b1, 1'b0, 1'b0, ~d, 1'b0);
            check(pin_out, gen_bit(~d, 1'b0), "R7 walk zero");
        end

        // R6: power-good low across modes and patterns
        for (int i = 0; i < 256; i++) begin
            apply(1'b0, 1'(i & 1), 1'((i >> 1) & 1), W'(i * 257 + 3), 1'((i >> 2) & 1));
            check(pin_oe, 1'b0, "R6 hiz");
            check(err_n, 1'b1, "R6 no err");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule